// File: doc/BRIEF.md
# Two-Phase Bus Processor Core

This block is a small 16-bit processor. It has four general registers, one internal bus that every transfer crosses, and a fixed-logic sequencer. Every instruction uses eight clocks. The first four clocks form the fetch phase: the program counter goes to the address register, the program counter steps, and the instruction register loads the addressed word. The last four clocks form the execute phase, and the selected operation moves data across the bus during those beats. Addition and subtraction run through two operand latches in front of the adder. A store or a load first routes a register value into the address register and then moves one word to or from memory.

The word memory sits inside the block and is read and written synchronously. A write port fills it while reset is held. The processor reads a switch bank through an input instruction and presents values on a registered output port through an output instruction. A one-clock strobe marks each new output value.

Top module: `bus_cpu16`

## Requirements
- R1: A synchronous active-high reset clears the program counter, the instruction register, all four registers, the output value and the strobe, and returns the sequencer to fetch beat 1. Execution then starts at address 0.
- R2: Each instruction takes exactly 8 clocks, 4 fetch beats followed by 4 execute beats. The program counter advances by one on the second fetch beat. Registers are never written during fetch.
- R3: The opcode is instruction bits [7:4] and is recognised only when bits [15:8] are zero. The destination field D is bits [3:2] and the source field S is bits [1:0]. The opcode values are 1 input, 2 subtract, 3 store, 4 load, 5 move, 6 add, 7 output and 8 jump.
- R4: Input writes the switch value into register D, and move copies register S into register D. Both take effect on the first execute beat.
- R5: Add writes D+S into register D, and subtract writes D−S into register D. Both wrap modulo 2^16.
- R6: Store writes register S to the memory word addressed by register D. Load writes the memory word addressed by register S into register D. Only the low 8 bits of the address register are used.
- R7: Output places register S on the output port, and the strobe is high for exactly the one clock after the first execute beat. The output value holds until the next output instruction.
- R8: Jump sets the program counter to the low 8 bits of register S, and the next fetch comes from that address.
- R9: An opcode outside 1..8 changes no register, memory word or output, and execution continues at the next address.
- R10: The program 0013 0017 0021 007C 001B 0038 0046 007D 0051 0061 007C 0013 008C, placed from address 0 and given switch values 04, 01, FF, 00 in that order, outputs 0x0003, 0x0003 and 0x0006, then jumps to 0 and repeats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_in | input | 16 | Switch bank read by the input instruction |
| load_we | input | 1 | Memory fill write enable |
| load_addr | input | 8 | Memory fill address |
| load_data | input | 16 | Memory fill data |
| out_data | output | 16 | Registered output port |
| out_valid | output | 1 | One-clock strobe for a new output value |

## Verification
The assertions assume that reset is held for at least one clock and that the memory fill port is used only while reset is asserted, so no fill write collides with a store. They also take the switch bank to matter only on the first execute beat of an input instruction. The stimulus fills memory under reset, provides the required switch value at exactly that beat, and places arbitrary values on the switches on every other clock to show they are ignored.

// File: rtl/bus_cpu16.sv
module bus_cpu16 #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] sw_in,
  input  logic          load_we,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  output logic [DW-1:0] out_data,
  output logic          out_valid
);
  localparam int DEPTH = 1 << AW;

  logic          m2;
  logic [1:0]    beat;
  logic [AW-1:0] pc, ar;
  logic [DW-1:0] ir, dr0, dr1, bus, alu;
  logic [DW-1:0] rf [4];
  logic [DW-1:0] mem [DEPTH];

  logic [1:0] rd, rs;
  logic [3:0] op;
  assign rd = ir[3:2];
  assign rs = ir[1:0];
  assign op = (ir[DW-1:8] == '0) ? ir[7:4] : 4'd0;

  logic i_in, i_sub, i_sta, i_ld, i_mov, i_add, i_out, i_jmp, arith, legal;
  assign i_in  = op == 4'd1;
  assign i_sub = op == 4'd2;
  assign i_sta = op == 4'd3;
  assign i_ld  = op == 4'd4;
  assign i_mov = op == 4'd5;
  assign i_add = op == 4'd6;
  assign i_out = op == 4'd7;
  assign i_jmp = op == 4'd8;
  assign arith = i_add | i_sub;
  assign legal = i_in | i_sub | i_sta | i_ld | i_mov | i_add | i_out | i_jmp;

  logic f1, f2, f3, x1, x2, x3;
  assign f1 = !m2 && beat == 2'd0;
  assign f2 = !m2 && beat == 2'd1;
  assign f3 = !m2 && beat == 2'd2;
  assign x1 =  m2 && beat == 2'd0;
  assign x2 =  m2 && beat == 2'd1;
  assign x3 =  m2 && beat == 2'd2;

  assign alu = i_sub ? dr0 - dr1 : dr0 + dr1;

  always_comb begin
    bus = '0;
    if (f1)      bus = {{(DW-AW){1'b0}}, pc};
    else if (f3) bus = mem[ar];
    else if (x1) begin
      if (i_in)               bus = sw_in;
      else if (arith | i_sta) bus = rf[rd];
      else                    bus = rf[rs];
    end
    else if (x2) bus = i_ld ? mem[ar] : rf[rs];
    else if (x3) bus = alu;
  end

  logic ar_ld, reg_we;
  assign ar_ld  = f1 | (x1 & (i_sta | i_ld));
  assign reg_we = (x1 & (i_in | i_mov)) | (x2 & i_ld) | (x3 & arith);

  always_ff @(posedge clk) begin
    if (rst) begin
      m2 <= 1'b0;
      beat <= 2'd0;
      pc <= '0;
      ar <= '0;
      ir <= '0;
      dr0 <= '0;
      dr1 <= '0;
      out_data <= '0;
      out_valid <= 1'b0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      beat <= beat + 2'd1;
      if (beat == 2'd3) m2 <= !m2;
      if (ar_ld) ar <= bus[AW-1:0];
      if (f2) pc <= pc + 1'b1;
      if (x1 & i_jmp) pc <= bus[AW-1:0];
      if (f3) ir <= bus;
      if (x1 & arith) dr0 <= bus;
      if (x2 & arith) dr1 <= bus;
      if (reg_we) rf[rd] <= bus;
      out_valid <= x1 & i_out;
      if (x1 & i_out) out_data <= bus;
    end
  end

  always_ff @(posedge clk) begin
    if (load_we) mem[load_addr] <= load_data;
    else if (x2 & i_sta) mem[ar] <= bus;
  end

  logic [4*DW-1:0] rf_flat;
  logic [AW-1:0]   rs_lo;
  assign rf_flat = {rf[3], rf[2], rf[1], rf[0]};
  assign rs_lo   = rf[rs][AW-1:0];

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    f2 |=> pc == $past(pc) + {{(AW-1){1'b0}}, 1'b1});

  assert_fetch_regs_R2: assert property (@(posedge clk) disable iff (rst)
    !m2 |=> $stable(rf_flat));

  assert_strobe_width_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  assert_out_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !x1 |=> $stable(out_data));

  assert_jump_R8: assert property (@(posedge clk) disable iff (rst)
    (x1 && i_jmp) |=> pc == $past(rs_lo));

  assert_undef_R9: assert property (@(posedge clk) disable iff (rst)
    (m2 && !legal) |=> ($stable(rf_flat) && !out_valid));
endmodule

// File: tb/sim_bus_cpu16.sv
module sim_bus_cpu16;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] sw_in = '0;
  logic        load_we = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [15:0] load_data = '0;
  logic [15:0] out_data;
  logic        out_valid;

  always #5 clk = ~clk;

  bus_cpu16 u0 (
    .clk(clk), .rst(rst), .sw_in(sw_in),
    .load_we(load_we), .load_addr(load_addr), .load_data(load_data),
    .out_data(out_data), .out_valid(out_valid)
  );

  int checks = 0;
  int errors = 0;
  int strobes = 0;
  int junk = 0;

  logic [15:0] img [256];
  logic [15:0] rm [256];
  logic [15:0] rr [4];
  logic [15:0] swq [$];
  int    rpc = 0;
  int    cyc = 0;
  bit    armed = 1'b0;
  logic  ev = 1'b0;
  logic [15:0] ed = '0;
  string tag = "R1";
  string prev_tag = "R1";
  string ptag = "";

  task automatic chk(input bit ok, input string t, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  function automatic string op_tag(input logic [15:0] w);
    if (w[15:8] != 8'h00) return "R3";
    case (w[7:4])
      4'd1, 4'd5: return "R4";
      4'd2, 4'd6: return "R5";
      4'd3, 4'd4: return "R6";
      4'd7:       return "R7";
      4'd8:       return "R8";
      default:    return "R9";
    endcase
  endfunction

  always @(negedge clk) begin
    if (armed) begin
      if (out_valid === 1'b1) strobes++;
      chk(out_valid === ev, "R2", {15'd0, out_valid}, {15'd0, ev});
      chk(out_data === ed, (ptag != "") ? ptag : tag, out_data, ed);
    end
    if (rst) begin
      rpc = 0; cyc = 0; ev = 1'b0; ed = '0; armed = 1'b1;
      for (int i = 0; i < 4; i++) rr[i] = '0;
      sw_in = 16'h5A00 ^ 16'(junk++);
    end else begin
      ev = 1'b0;
      if (cyc == 4) begin
        logic [15:0] w;
        logic [3:0]  op;
        int d, s;
        w = rm[rpc];
        op = (w[15:8] == 8'h00) ? w[7:4] : 4'd0;
        d = int'(w[3:2]);
        s = int'(w[1:0]);
        rpc = (rpc + 1) % 256;
        if (op == 4'd1) sw_in = (swq.size() > 0) ? swq.pop_front() : 16'h0000;
        else sw_in = 16'h5A00 ^ 16'(junk++);
        case (op)
          4'd1: rr[d] = sw_in;
          4'd2: rr[d] = rr[d] - rr[s];
          4'd3: rm[rr[d][7:0]] = rr[s];
          4'd4: rr[d] = rm[rr[s][7:0]];
          4'd5: rr[d] = rr[s];
          4'd6: rr[d] = rr[d] + rr[s];
          4'd7: begin ev = 1'b1; ed = rr[s]; end
          4'd8: rpc = int'(rr[s][7:0]);
          default: ;
        endcase
        if (op == 4'd7) tag = prev_tag;
        else prev_tag = op_tag(w);
      end else begin
        sw_in = 16'h5A00 ^ 16'(junk++);
      end
      cyc = (cyc + 1) % 8;
    end
    if (load_we) rm[load_addr] = load_data;
  end

  task automatic run_image(input int cycles);
    @(posedge clk); #2;
    rst = 1'b1;
    for (int a = 0; a < 256; a++) begin
      load_we = 1'b1; load_addr = 8'(a); load_data = img[a];
      @(posedge clk); #2;
    end
    load_we = 1'b0;
    @(posedge clk); #2;
    rst = 1'b0;
    @(negedge clk);
    chk(out_data === 16'h0000 && out_valid === 1'b0, "R1", out_data, 16'h0000);
    strobes = 0;
    repeat (cycles) @(posedge clk);
    #2;
  endtask

  task automatic clear_img;
    for (int a = 0; a < 256; a++) img[a] = 16'h0000;
  endtask

  initial begin
    ptag = "";
    clear_img();
    img[8'h00] = 16'h001C; img[8'h01] = 16'h0018; img[8'h02] = 16'h006E;
    img[8'h03] = 16'h0073; img[8'h04] = 16'h0014; img[8'h05] = 16'h0026;
    img[8'h06] = 16'h0071; img[8'h07] = 16'h0051; img[8'h08] = 16'h0070;
    img[8'h09] = 16'h0152; img[8'h0A] = 16'h0070; img[8'h0B] = 16'h0090;
    img[8'h0C] = 16'h0070; img[8'h0D] = 16'h0018; img[8'h0E] = 16'h0039;
    img[8'h0F] = 16'h0010; img[8'h10] = 16'h004C; img[8'h11] = 16'h0073;
    img[8'h12] = 16'h0014; img[8'h13] = 16'h0081; img[8'h14] = 16'h0071;
    img[8'h20] = 16'h0072;
    swq = '{16'hFFFF, 16'h0001, 16'h0000, 16'h1234, 16'h0034, 16'h0120};
    run_image(320);
    chk(strobes == 7, "R8", 16'(strobes), 16'd7);

    ptag = "R1";
    clear_img();
    img[0] = 16'h0070; img[1] = 16'h0071; img[2] = 16'h0072; img[3] = 16'h0073;
    swq = {};
    run_image(80);
    chk(strobes == 4, "R1", 16'(strobes), 16'd4);

    ptag = "R10";
    clear_img();
    img[8'h00] = 16'h0013; img[8'h01] = 16'h0017; img[8'h02] = 16'h0021;
    img[8'h03] = 16'h007C; img[8'h04] = 16'h001B; img[8'h05] = 16'h0038;
    img[8'h06] = 16'h0046; img[8'h07] = 16'h007D; img[8'h08] = 16'h0051;
    img[8'h09] = 16'h0061; img[8'h0A] = 16'h007C; img[8'h0B] = 16'h0013;
    img[8'h0C] = 16'h008C;
    swq = {};
    for (int k = 0; k < 3; k++) begin
      swq.push_back(16'h0004); swq.push_back(16'h0001);
      swq.push_back(16'h00FF); swq.push_back(16'h0000);
    end
    run_image(216);
    chk(strobes == 6, "R10", 16'(strobes), 16'd6);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule